// File: doc/BRIEF.md
# Sequenced Windowed Watchdog

This block supervises a processor by demanding that it prove it is alive at the right time and in the right order. After every restart a closed phase runs for a set number of cycles. During that phase any service request counts as premature. An open phase follows and lasts until a hard deadline. A service request inside the open phase carries an operand, and that operand must equal the expected sequence value the block publishes. A correct request restarts the timer and steps the expected value forward by one. A request that comes too soon, one that carries the wrong value, or no request before the deadline all trigger a system reset pulse. The block latches a code that records why the reset happened.

The processor reads `expectSeq` and writes it back with `clearStb`. A runaway program that writes the watchdog repeatedly, or with a stale value, is therefore caught, as is one that stops writing altogether. After each reset pulse the block restarts in the closed phase.

Top module: `seq_watchdog`

## Requirements
- R1: While `rst_n` is low and after its release, `sysRst` is 0, `rstCause` is 00 (none) and `expectSeq` is 0.
- R2: A `clearStb` seen while fewer than CLOSED_CYC cycles have passed since the last restart starts a reset pulse on the next cycle and sets `rstCause` to 01 (early).
- R3: If TIMEOUT_CYC cycles pass after a restart with no accepted clear, a reset pulse starts on the following cycle and `rstCause` becomes 10 (timeout).
- R4: A `clearStb` in the open phase whose `clearOperand` differs from `expectSeq` starts a reset pulse on the next cycle and sets `rstCause` to 11 (sequence mismatch).
- R5: A `clearStb` in the open phase whose operand equals `expectSeq` raises no reset, increments `expectSeq` by one on the next cycle, and restarts the cycle count from zero.
- R6: `sysRst` stays high for exactly PULSE_CYC cycles. When it falls, the cycle count is zero and the closed phase begins again.
- R7: While `sysRst` is high, `clearStb` has no effect: the pulse length and `expectSeq` do not change.
- R8: A matching clear on the last open cycle (count TIMEOUT_CYC-1) is accepted and overrides the timeout in that same cycle.
- R9: The open phase begins exactly at count CLOSED_CYC. A clear at count CLOSED_CYC-1 is early, and a matching clear at count CLOSED_CYC is accepted.
- R10: `expectSeq` wraps from its all-ones value to 0 modulo 2^SEQ_W.
- R11: `rstCause` changes only when a reset pulse starts. Accepted clears leave it untouched.
- R12: A watchdog reset does not change `expectSeq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clearStb | input | 1 | Service request strobe, one cycle per request |
| clearOperand | input | SEQ_W | Sequence value carried with the request |
| sysRst | output | 1 | System reset pulse |
| expectSeq | output | SEQ_W | Sequence value the next request must carry |
| rstCause | output | 2 | Reason for the last reset: 00 none, 01 early, 10 timeout, 11 mismatch |

## Verification
A service request can coincide with the deadline. A matching request driven at count TIMEOUT_CYC-1 must be accepted, the timeout must be dropped, and no pulse may appear afterward. A request can also coincide with an active reset pulse. Requests carrying the correct operand are driven throughout a pulse, and the bench then checks that the pulse keeps its exact length and that the sequence value does not advance.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_EARLY = 2'b01,
    CAUSE_LATE  = 2'b10,
    CAUSE_SEQ   = 2'b11
  } cause_t;

  typedef struct packed {
    logic   timerClr;
    logic   timerInc;
    logic   seqAdv;
    logic   pulseClr;
    logic   pulseInc;
    logic   causeLoad;
    cause_t causeVal;
  } ctrl_t;

endpackage

// File: rtl/swd_datapath.sv
module swd_datapath
  import swd_pkg::*;
#(
  parameter int CLOSED_CYC  = 8,
  parameter int TIMEOUT_CYC = 20,
  parameter int PULSE_CYC   = 4,
  parameter int SEQ_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [SEQ_W-1:0] clearOperand,
  output logic             inWindow,
  output logic             timerExpire,
  output logic             seqMatch,
  output logic             pulseDone,
  output logic [SEQ_W-1:0] expectSeq,
  output logic [1:0]       rstCause
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [TW-1:0] OPEN_AT  = TW'(CLOSED_CYC);
  localparam logic [TW-1:0] LAST_CNT = TW'(TIMEOUT_CYC - 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_CYC - 1);

  logic [TW-1:0]    timerCnt;
  logic [PW-1:0]    pulseCnt;
  logic [SEQ_W-1:0] seqReg;
  cause_t           causeReg;

  // cycle count since the last restart
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timerCnt <= '0;
    end else if (ctrl.timerClr) begin
      timerCnt <= '0;
    end else if (ctrl.timerInc) begin
      timerCnt <= timerCnt + 1'b1;
    end
  end

  // length of the reset pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulseCnt <= '0;
    end else if (ctrl.pulseClr) begin
      pulseCnt <= '0;
    end else if (ctrl.pulseInc) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  // expected sequence value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seqReg <= '0;
    end else if (ctrl.seqAdv) begin
      seqReg <= seqReg + 1'b1;
    end
  end

  // latched reason for the last reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      causeReg <= CAUSE_NONE;
    end else if (ctrl.causeLoad) begin
      causeReg <= ctrl.causeVal;
    end
  end

  assign inWindow    = (timerCnt >= OPEN_AT);
  assign timerExpire = (timerCnt == LAST_CNT);
  assign seqMatch    = (clearOperand == seqReg);
  assign pulseDone   = (pulseCnt == PULSE_LAST);
  assign expectSeq   = seqReg;
  assign rstCause    = causeReg;

endmodule

// File: rtl/swd_control.sv
module swd_control
  import swd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clearStb,
  input  logic  inWindow,
  input  logic  timerExpire,
  input  logic  seqMatch,
  input  logic  pulseDone,
  output ctrl_t ctrl,
  output logic  sysRst
);

  typedef enum logic {ST_RUN, ST_PULSE} state_t;

  state_t state, nextState;
  logic   fault;
  cause_t faultCause;

  // fault decision; a request takes priority over the deadline in the same cycle
  always_comb begin
    fault      = 1'b0;
    faultCause = CAUSE_NONE;
    if (state == ST_RUN) begin
      if (clearStb) begin
        if (!inWindow) begin
          fault      = 1'b1;
          faultCause = CAUSE_EARLY;
        end else if (!seqMatch) begin
          fault      = 1'b1;
          faultCause = CAUSE_SEQ;
        end
      end else if (timerExpire) begin
        fault      = 1'b1;
        faultCause = CAUSE_LATE;
      end
    end
  end

  always_comb begin
    ctrl      = '0;
    nextState = state;
    unique case (state)
      ST_RUN: begin
        if (fault) begin
          nextState      = ST_PULSE;
          ctrl.causeLoad = 1'b1;
          ctrl.causeVal  = faultCause;
          ctrl.timerClr  = 1'b1;
          ctrl.pulseClr  = 1'b1;
        end else if (clearStb) begin
          ctrl.timerClr = 1'b1;
          ctrl.seqAdv   = 1'b1;
        end else begin
          ctrl.timerInc = 1'b1;
        end
      end
      ST_PULSE: begin
        if (pulseDone) begin
          nextState     = ST_RUN;
          ctrl.timerClr = 1'b1;
        end else begin
          ctrl.pulseInc = 1'b1;
        end
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
    end else begin
      state <= nextState;
    end
  end

  assign sysRst = (state == ST_PULSE);

endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog
  import swd_pkg::*;
#(
  parameter int CLOSED_CYC  = 8,
  parameter int TIMEOUT_CYC = 20,
  parameter int PULSE_CYC   = 4,
  parameter int SEQ_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clearStb,
  input  logic [SEQ_W-1:0] clearOperand,
  output logic             sysRst,
  output logic [SEQ_W-1:0] expectSeq,
  output logic [1:0]       rstCause
);

  ctrl_t ctrl;
  logic  inWindow, timerExpire, seqMatch, pulseDone;

  swd_control ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clearStb    (clearStb),
    .inWindow    (inWindow),
    .timerExpire (timerExpire),
    .seqMatch    (seqMatch),
    .pulseDone   (pulseDone),
    .ctrl        (ctrl),
    .sysRst      (sysRst)
  );

  swd_datapath #(
    .CLOSED_CYC  (CLOSED_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .PULSE_CYC   (PULSE_CYC),
    .SEQ_W       (SEQ_W)
  ) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl         (ctrl),
    .clearOperand (clearOperand),
    .inWindow     (inWindow),
    .timerExpire  (timerExpire),
    .seqMatch     (seqMatch),
    .pulseDone    (pulseDone),
    .expectSeq    (expectSeq),
    .rstCause     (rstCause)
  );

endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
  parameter int SEQ_W     = 8,
  parameter int PULSE_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sysRst,
  input logic [SEQ_W-1:0] expectSeq,
  input logic [1:0]       rstCause
);

  int unsigned highRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      highRun <= 0;
    end else if (sysRst) begin
      highRun <= highRun + 1;
    end else begin
      highRun <= 0;
    end
  end

  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    sysRst |-> (highRun < PULSE_CYC)); // R6

  AST_PULSE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sysRst) |-> (highRun == PULSE_CYC)); // R6

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (expectSeq != $past(expectSeq)) |-> (expectSeq == SEQ_W'($past(expectSeq) + 1'b1))); // R5

  AST_SEQ_FROZEN_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sysRst |=> $stable(expectSeq)); // R7

  AST_CAUSE_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysRst) |-> (rstCause != 2'b00)); // R2

  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sysRst) |-> $stable(rstCause)); // R11

endmodule

bind seq_watchdog swd_checker #(
  .SEQ_W     (SEQ_W),
  .PULSE_CYC (PULSE_CYC)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sysRst    (sysRst),
  .expectSeq (expectSeq),
  .rstCause  (rstCause)
);

// File: tb/seq_watchdog_tb_top.sv
module seq_watchdog_tb_top;

  localparam int T1 = 6;
  localparam int T3 = 14;
  localparam int P  = 3;
  localparam int W  = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clearStb = 1'b0;
  logic [W-1:0] clearOperand = '0;
  logic         sysRst;
  logic [W-1:0] expectSeq;
  logic [1:0]   rstCause;

  int checks = 0;
  int fails  = 0;
  int seqModel = 0;

  always #5 clk = ~clk;

  seq_watchdog #(
    .CLOSED_CYC  (T1),
    .TIMEOUT_CYC (T3),
    .PULSE_CYC   (P),
    .SEQ_W       (W)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clearStb     (clearStb),
    .clearOperand (clearOperand),
    .sysRst       (sysRst),
    .expectSeq    (expectSeq),
    .rstCause     (rstCause)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one-cycle request; returns at the next falling edge
  task automatic doClear(input int op);
    clearStb     = 1'b1;
    clearOperand = W'(op);
    @(negedge clk);
    clearStb     = 1'b0;
  endtask

  // called on the first pulse cycle; returns when the count is back at zero
  task automatic checkPulse(input string req, input int cause, input bit pokeDuring);
    chk({req, " cause"}, rstCause, cause);
    for (int i = 0; i < P; i++) begin
      chk({req, " R6 pulse high"}, sysRst, 1);
      if (pokeDuring) begin
        clearStb     = 1'b1;
        clearOperand = W'(seqModel);
      end
      @(negedge clk);
    end
    clearStb = 1'b0;
    chk({req, " R6 pulse ends"}, sysRst, 0);
    chk({req, " R12 seq kept"}, expectSeq, seqModel);
  endtask

  task automatic testReset();
    rst_n = 1'b0;
    waitCycles(3);
    chk("R1 sysRst in reset", sysRst, 0);
    chk("R1 cause in reset", rstCause, 0);
    chk("R1 seq in reset", expectSeq, 0);
    rst_n = 1'b1;
    seqModel = 0;
    chk("R1 sysRst after release", sysRst, 0);
  endtask

  task automatic testOpenBoundary();
    waitCycles(T1);
    doClear(seqModel);
    seqModel = (seqModel + 1) % (1 << W);
    chk("R9 clear at open edge no reset", sysRst, 0);
    chk("R5 seq advanced", expectSeq, seqModel);
    chk("R11 cause untouched by accept", rstCause, 0);
  endtask

  task automatic testEarly();
    waitCycles(T1 - 1);
    doClear(seqModel);
    chk("R9 clear one cycle early resets", sysRst, 1);
    checkPulse("R2", 1, 1'b0);
  endtask

  task automatic testPulseRestartAndIgnore();
    // count is zero after the pulse, so an immediate request is early
    doClear(seqModel);
    chk("R6 closed phase after pulse", sysRst, 1);
    checkPulse("R7", 1, 1'b1);
  endtask

  task automatic testTimeout();
    waitCycles(T3 - 1);
    chk("R3 no reset before deadline", sysRst, 0);
    @(negedge clk);
    chk("R3 reset at deadline", sysRst, 1);
    checkPulse("R3", 2, 1'b0);
  endtask

  task automatic testMismatch();
    waitCycles(T1 + 2);
    doClear((seqModel + 1) % (1 << W));
    chk("R4 mismatch resets", sysRst, 1);
    checkPulse("R4", 3, 1'b0);
  endtask

  task automatic testLastCycle();
    waitCycles(T3 - 1);
    doClear(seqModel);
    seqModel = (seqModel + 1) % (1 << W);
    chk("R8 last-cycle clear no reset", sysRst, 0);
    chk("R8 seq advanced", expectSeq, seqModel);
    chk("R11 cause still mismatch", rstCause, 3);
    // restart from zero: a full T3-1 cycles pass quietly
    waitCycles(T3 - 1);
    chk("R5 count restarted", sysRst, 0);
    doClear(seqModel);
    seqModel = (seqModel + 1) % (1 << W);
    chk("R5 second accept", sysRst, 0);
  endtask

  task automatic testWrap();
    int start;
    bit sawZero;
    start = seqModel;
    sawZero = 1'b0;
    for (int k = 0; k < (1 << W); k++) begin
      waitCycles(T1);
      doClear(seqModel);
      seqModel = (seqModel + 1) % (1 << W);
      if (expectSeq == 0) sawZero = 1'b1;
    end
    chk("R10 seq wrapped to start", expectSeq, start);
    chk("R10 seq passed zero", sawZero, 1);
    chk("R10 no reset during wrap", sysRst, 0);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testOpenBoundary();
    testEarly();
    testPulseRestartAndIgnore();
    testTimeout();
    testMismatch();
    testLastCycle();
    testWrap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule